// File: doc/BRIEF.md
# Wrong-Path Fault Distance Predictor

This block is a direct-mapped learning table. It is used after an instruction has shown behaviour that is illegal or unlikely on the correct path, which suggests the machine is running down a mispredicted path. For such a faulting instruction, the table predicts how many instructions back the mispredicted branch sits. The lookup side takes the faulting instruction's PC and the recent global branch history. One cycle later it returns a hit flag, a distance and, when one was learned, a redirect target for an indirect branch. The caller counts back that many sequence numbers from the faulting instruction and decides whether to recover that branch.

The update side is driven when the oldest mispredicted branch retires. The caller supplies the following:
- whether a fault was seen on that branch's wrong path;
- the PC, history and sequence number of the oldest such fault;
- the branch's own sequence number and resolved target;
- whether the branch was indirect;
- a kill request, raised when an earlier prediction from this entry recovered a branch older than the real culprit.

An update FSM spreads the work over three cycles. The states are `UPD_IDLE`, `UPD_HASH` and `UPD_COMMIT`. The transitions are:
- `UPD_IDLE` to `UPD_HASH` when an update that carries a fault is accepted (`start`);
- `UPD_HASH` to `UPD_COMMIT` unconditionally (`hashed`);
- `UPD_COMMIT` to `UPD_IDLE` unconditionally (`written`).

Every other case holds `UPD_IDLE`.

Top module: `wpe_dist_pred`

## Requirements
- R1: After reset every entry is invalid, so any lookup returns `rsp_hit` = 0.
- R2: The entry index is `pc[IDX_W-1:0] XOR hist`. Two different PC/history pairs with the same XOR share one entry.
- R3: An accepted update with `up_wpe_seen` = 1 and `up_kill` = 0 marks its entry valid. It stores the distance `(up_wpe_seq - up_br_seq) mod 2^SEQ_W`, including when the sequence numbers wrap.
- R4: An update with `up_wpe_seen` = 0 leaves the table unchanged, whatever its other fields hold.
- R5: An accepted update with `up_wpe_seen` = 1 and `up_kill` = 1 clears the valid bit of its entry. Later lookups of that entry miss.
- R6: A written update with `up_is_indirect` = 1 stores `up_br_tgt` and sets `rsp_tgt_ok` for that entry. A written update with `up_is_indirect` = 0 clears `rsp_tgt_ok`.
- R7: `rsp_valid` is high exactly one cycle after a cycle with `lk_req` high. The response reflects the table as it stood before that clock edge.
- R8: After an update carrying a fault is accepted, `up_ready` is low for the next two cycles. The entry is written on the third edge. Updates offered while `up_ready` is low are ignored.
- R9: When `rsp_hit` is 0, `rsp_dist`, `rsp_tgt_ok` and `rsp_tgt` are all 0 (no prediction).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_pc | input | PC_W | PC of faulting instruction |
| lk_hist | input | IDX_W | Recent global branch history |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Entry was valid |
| rsp_dist | output | SEQ_W | Predicted distance back to the branch |
| rsp_tgt_ok | output | 1 | Stored indirect target is present |
| rsp_tgt | output | PC_W | Stored indirect target |
| up_valid | input | 1 | Update offered |
| up_ready | output | 1 | Update side idle and accepting |
| up_wpe_seen | input | 1 | A fault occurred on the wrong path |
| up_kill | input | 1 | Invalidate entry instead of training it |
| up_is_indirect | input | 1 | Retiring branch was indirect |
| up_wpe_pc | input | PC_W | PC of oldest fault |
| up_wpe_hist | input | IDX_W | History at oldest fault |
| up_wpe_seq | input | SEQ_W | Sequence number of oldest fault |
| up_br_seq | input | SEQ_W | Sequence number of the branch |
| up_br_tgt | input | PC_W | Resolved target of the branch |

## Verification
A lookup result is due one clock edge after the request. The bench raises `lk_req` on a falling edge and reads the response on the following falling edge, then lowers the request and checks that `rsp_valid` has dropped. An accepted update holds `up_ready` low at the two falling edges that follow and lands in the table on the third rising edge. The bench therefore checks `up_ready` at each of those falling edges and only issues its next lookup once `up_ready` is back high. A reference model is updated at that same point, so each expected value matches the table contents at the edge where the lookup samples them.

// File: rtl/wpe_dp_pkg.sv
package wpe_dp_pkg;
    typedef enum logic [1:0] {
        UPD_IDLE   = 2'd0,
        UPD_HASH   = 2'd1,
        UPD_COMMIT = 2'd2
    } upd_state_t;
endpackage

// File: rtl/wpe_dp_hash.sv
module wpe_dp_hash #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [IDX_W-1:0] hist,
    output logic [IDX_W-1:0] idx
);
    for (genvar b = 0; b < IDX_W; b++) begin : g_bit
        assign idx[b] = pc[b] ^ hist[b];
    end
endmodule

// File: rtl/wpe_dp_upd_fsm.sv
module wpe_dp_upd_fsm
    import wpe_dp_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6,
    parameter int SEQ_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_valid,
    input  logic             up_wpe_seen,
    input  logic             up_kill,
    input  logic             up_is_indirect,
    input  logic [PC_W-1:0]  up_wpe_pc,
    input  logic [IDX_W-1:0] up_wpe_hist,
    input  logic [SEQ_W-1:0] up_wpe_seq,
    input  logic [SEQ_W-1:0] up_br_seq,
    input  logic [PC_W-1:0]  up_br_tgt,
    output logic             up_ready,
    output logic             wr_en,
    output logic             wr_kill,
    output logic [IDX_W-1:0] wr_idx,
    output logic [SEQ_W-1:0] wr_dist,
    output logic             wr_tok,
    output logic [PC_W-1:0]  wr_tgt
);
    upd_state_t state_q, state_d;

    logic [PC_W-1:0]  pc_q;
    logic [IDX_W-1:0] hist_q;
    logic [SEQ_W-1:0] wseq_q, bseq_q;
    logic             kill_q, ind_q;
    logic [IDX_W-1:0] hash_idx;
    logic             start;

    assign start = up_valid && up_wpe_seen && (state_q == UPD_IDLE);

    wpe_dp_hash #(.PC_W(PC_W), .IDX_W(IDX_W)) u_hash (
        .pc   (pc_q),
        .hist (hist_q),
        .idx  (hash_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= UPD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UPD_IDLE:   if (start) state_d = UPD_HASH;
            UPD_HASH:   state_d = UPD_COMMIT;
            UPD_COMMIT: state_d = UPD_IDLE;
            default:    state_d = UPD_IDLE;
        endcase
    end

    always_comb begin
        up_ready = 1'b0;
        wr_en    = 1'b0;
        unique case (state_q)
            UPD_IDLE:   up_ready = 1'b1;
            UPD_HASH:   ;
            UPD_COMMIT: wr_en = 1'b1;
            default:    ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (start) begin
            pc_q   <= up_wpe_pc;
            hist_q <= up_wpe_hist;
            wseq_q <= up_wpe_seq;
            bseq_q <= up_br_seq;
            kill_q <= up_kill;
            ind_q  <= up_is_indirect;
            wr_tgt <= up_br_tgt;
        end
        if (state_q == UPD_HASH) begin
            wr_idx  <= hash_idx;
            wr_dist <= wseq_q - bseq_q;
            wr_kill <= kill_q;
            wr_tok  <= ind_q;
        end
    end

    AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en && up_ready); // R8
    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !up_ready ##1 !up_ready); // R8
endmodule

// File: rtl/wpe_dp_table.sv
module wpe_dp_table #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6,
    parameter int SEQ_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             wr_en,
    input  logic             wr_kill,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [SEQ_W-1:0] wr_dist,
    input  logic             wr_tok,
    input  logic [PC_W-1:0]  wr_tgt,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [SEQ_W-1:0] rsp_dist,
    output logic             rsp_tgt_ok,
    output logic [PC_W-1:0]  rsp_tgt
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] tok_q;
    logic [SEQ_W-1:0] dist_q [DEPTH];
    logic [PC_W-1:0]  tgt_q  [DEPTH];
    logic             filled_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q    <= '0;
            filled_q <= 1'b0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= !wr_kill;
            if (!wr_kill) filled_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !wr_kill) begin
            dist_q[wr_idx] <= wr_dist;
            tok_q[wr_idx]  <= wr_tok;
            tgt_q[wr_idx]  <= wr_tgt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_dist   <= '0;
            rsp_tgt_ok <= 1'b0;
            rsp_tgt    <= '0;
        end else begin
            rsp_valid  <= rd_en;
            rsp_hit    <= rd_en && vld_q[rd_idx];
            rsp_dist   <= (rd_en && vld_q[rd_idx]) ? dist_q[rd_idx] : '0;
            rsp_tgt_ok <= rd_en && vld_q[rd_idx] && tok_q[rd_idx];
            rsp_tgt    <= (rd_en && vld_q[rd_idx] && tok_q[rd_idx]) ? tgt_q[rd_idx] : '0;
        end
    end

    AST_HIT_NEEDS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> filled_q); // R1
    AST_MISS_IS_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_dist == '0) && !rsp_tgt_ok && (rsp_tgt == '0)); // R9
    AST_HIT_HAS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid); // R7
endmodule

// File: rtl/wpe_dist_pred.sv
module wpe_dist_pred #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6,
    parameter int SEQ_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_req,
    input  logic [PC_W-1:0]  lk_pc,
    input  logic [IDX_W-1:0] lk_hist,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [SEQ_W-1:0] rsp_dist,
    output logic             rsp_tgt_ok,
    output logic [PC_W-1:0]  rsp_tgt,
    input  logic             up_valid,
    output logic             up_ready,
    input  logic             up_wpe_seen,
    input  logic             up_kill,
    input  logic             up_is_indirect,
    input  logic [PC_W-1:0]  up_wpe_pc,
    input  logic [IDX_W-1:0] up_wpe_hist,
    input  logic [SEQ_W-1:0] up_wpe_seq,
    input  logic [SEQ_W-1:0] up_br_seq,
    input  logic [PC_W-1:0]  up_br_tgt
);
    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic             wr_en, wr_kill, wr_tok;
    logic [SEQ_W-1:0] wr_dist;
    logic [PC_W-1:0]  wr_tgt;

    wpe_dp_hash #(.PC_W(PC_W), .IDX_W(IDX_W)) u_rd_hash (
        .pc   (lk_pc),
        .hist (lk_hist),
        .idx  (rd_idx)
    );

    wpe_dp_upd_fsm #(.PC_W(PC_W), .IDX_W(IDX_W), .SEQ_W(SEQ_W)) u_upd (
        .clk            (clk),
        .rst_n          (rst_n),
        .up_valid       (up_valid),
        .up_wpe_seen    (up_wpe_seen),
        .up_kill        (up_kill),
        .up_is_indirect (up_is_indirect),
        .up_wpe_pc      (up_wpe_pc),
        .up_wpe_hist    (up_wpe_hist),
        .up_wpe_seq     (up_wpe_seq),
        .up_br_seq      (up_br_seq),
        .up_br_tgt      (up_br_tgt),
        .up_ready       (up_ready),
        .wr_en          (wr_en),
        .wr_kill        (wr_kill),
        .wr_idx         (wr_idx),
        .wr_dist        (wr_dist),
        .wr_tok         (wr_tok),
        .wr_tgt         (wr_tgt)
    );

    wpe_dp_table #(.PC_W(PC_W), .IDX_W(IDX_W), .SEQ_W(SEQ_W)) u_tab (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (lk_req),
        .rd_idx     (rd_idx),
        .wr_en      (wr_en),
        .wr_kill    (wr_kill),
        .wr_idx     (wr_idx),
        .wr_dist    (wr_dist),
        .wr_tok     (wr_tok),
        .wr_tgt     (wr_tgt),
        .rsp_valid  (rsp_valid),
        .rsp_hit    (rsp_hit),
        .rsp_dist   (rsp_dist),
        .rsp_tgt_ok (rsp_tgt_ok),
        .rsp_tgt    (rsp_tgt)
    );

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid); // R7
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid); // R7
endmodule

// File: tb/wpe_dist_pred_tb_top.sv
module wpe_dist_pred_tb_top;
    localparam int PC_W  = 32;
    localparam int IDX_W = 6;
    localparam int SEQ_W = 9;
    localparam int DEPTH = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_req = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic [IDX_W-1:0] lk_hist = '0;
    logic rsp_valid, rsp_hit, rsp_tgt_ok, up_ready;
    logic [SEQ_W-1:0] rsp_dist;
    logic [PC_W-1:0] rsp_tgt;
    logic up_valid = 1'b0, up_wpe_seen = 1'b0, up_kill = 1'b0, up_is_indirect = 1'b0;
    logic [PC_W-1:0] up_wpe_pc = '0, up_br_tgt = '0;
    logic [IDX_W-1:0] up_wpe_hist = '0;
    logic [SEQ_W-1:0] up_wpe_seq = '0, up_br_seq = '0;

    always #5 clk = ~clk;

    wpe_dist_pred #(.PC_W(PC_W), .IDX_W(IDX_W), .SEQ_W(SEQ_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_pc(lk_pc), .lk_hist(lk_hist),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_dist(rsp_dist),
        .rsp_tgt_ok(rsp_tgt_ok), .rsp_tgt(rsp_tgt), .up_valid(up_valid),
        .up_ready(up_ready), .up_wpe_seen(up_wpe_seen), .up_kill(up_kill),
        .up_is_indirect(up_is_indirect), .up_wpe_pc(up_wpe_pc), .up_wpe_hist(up_wpe_hist),
        .up_wpe_seq(up_wpe_seq), .up_br_seq(up_br_seq), .up_br_tgt(up_br_tgt)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    bit             m_vld [DEPTH];
    bit             m_tok [DEPTH];
    logic [SEQ_W-1:0] m_dist [DEPTH];
    logic [PC_W-1:0]  m_tgt [DEPTH];

    function automatic logic [IDX_W-1:0] f_idx(logic [PC_W-1:0] pc, logic [IDX_W-1:0] h);
        return pc[IDX_W-1:0] ^ h;
    endfunction

    function automatic logic [SEQ_W-1:0] f_dist(logic [SEQ_W-1:0] w, logic [SEQ_W-1:0] b);
        int unsigned d;
        d = (int'(w) - int'(b) + (1 << SEQ_W)) % (1 << SEQ_W);
        return d[SEQ_W-1:0];
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    task automatic model_write(logic seen, logic kill, logic ind, logic [PC_W-1:0] pc,
                               logic [IDX_W-1:0] h, logic [SEQ_W-1:0] ws,
                               logic [SEQ_W-1:0] bs, logic [PC_W-1:0] tg);
        logic [IDX_W-1:0] i;
        i = f_idx(pc, h);
        if (!seen) return;
        if (kill) m_vld[i] = 1'b0;
        else begin
            m_vld[i] = 1'b1; m_dist[i] = f_dist(ws, bs);
            m_tok[i] = ind;  m_tgt[i] = tg;
        end
    endtask

    // Presents an update on a falling edge; returns after it has landed.
    task automatic do_update(logic seen, logic kill, logic ind, logic [PC_W-1:0] pc,
                             logic [IDX_W-1:0] h, logic [SEQ_W-1:0] ws,
                             logic [SEQ_W-1:0] bs, logic [PC_W-1:0] tg, bit chk_busy);
        up_valid = 1'b1; up_wpe_seen = seen; up_kill = kill; up_is_indirect = ind;
        up_wpe_pc = pc; up_wpe_hist = h; up_wpe_seq = ws; up_br_seq = bs; up_br_tgt = tg;
        @(posedge clk); @(negedge clk);
        up_valid = 1'b0;
        if (seen) begin
            if (chk_busy) chk(up_ready == 1'b0, "R8 busy1", 64'(up_ready), 0);
            @(negedge clk);
            if (chk_busy) chk(up_ready == 1'b0, "R8 busy2", 64'(up_ready), 0);
            @(negedge clk);
            if (chk_busy) chk(up_ready == 1'b1, "R8 ready", 64'(up_ready), 1);
        end
        model_write(seen, kill, ind, pc, h, ws, bs, tg);
    endtask

    task automatic do_lookup(logic [PC_W-1:0] pc, logic [IDX_W-1:0] h, string tag);
        logic [IDX_W-1:0] i;
        i = f_idx(pc, h);
        lk_req = 1'b1; lk_pc = pc; lk_hist = h;
        @(posedge clk); @(negedge clk);
        lk_req = 1'b0;
        chk(rsp_valid == 1'b1, {tag, " R7 valid"}, 64'(rsp_valid), 1);
        chk(rsp_hit == m_vld[i], {tag, " hit"}, 64'(rsp_hit), 64'(m_vld[i]));
        chk(rsp_dist == (m_vld[i] ? m_dist[i] : '0), {tag, " dist"},
            64'(rsp_dist), 64'(m_vld[i] ? m_dist[i] : '0));
        chk(rsp_tgt_ok == (m_vld[i] && m_tok[i]), {tag, " R6 tok"},
            64'(rsp_tgt_ok), 64'(m_vld[i] && m_tok[i]));
        chk(rsp_tgt == ((m_vld[i] && m_tok[i]) ? m_tgt[i] : '0), {tag, " R6 tgt"},
            64'(rsp_tgt), 64'((m_vld[i] && m_tok[i]) ? m_tgt[i] : '0));
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc);
                summary();
            end
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        for (int k = 0; k < DEPTH; k++) begin
            m_vld[k] = 1'b0; m_tok[k] = 1'b0; m_dist[k] = '0; m_tgt[k] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(up_ready == 1'b1, "R1 ready after reset", 64'(up_ready), 1);
        chk(rsp_valid == 1'b0, "R7 idle rsp", 64'(rsp_valid), 0);
        do_lookup(32'h0000_1234, 6'h15, "R1 empty");
        do_lookup(32'h0000_0000, 6'h00, "R1 empty0");
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R7 drop", 64'(rsp_valid), 0);

        // R3 with wrap: (3 - 500) mod 512 = 15
        do_update(1, 0, 0, 32'h0000_4008, 6'h0C, 9'd3, 9'd500, 32'hDEAD_0000, 1);
        do_lookup(32'h0000_4008, 6'h0C, "R3 wrap");
        chk(rsp_dist == 9'd15, "R3 wrap dist", 64'(rsp_dist), 15);

        // R2 alias: 0x08^0x0C = 0x04; 0x05^0x01 = 0x04 same entry
        do_lookup(32'h0000_0005, 6'h01, "R2 alias");
        chk(rsp_hit == 1'b1, "R2 alias hit", 64'(rsp_hit), 1);

        // R6 indirect target stored, then non-indirect clears flag
        do_update(1, 0, 1, 32'h0000_0021, 6'h10, 9'd40, 9'd10, 32'hCAFE_0044, 1);
        do_lookup(32'h0000_0021, 6'h10, "R6 ind");
        chk(rsp_tgt == 32'hCAFE_0044, "R6 tgt value", 64'(rsp_tgt), 64'h CAFE0044);
        do_update(1, 0, 0, 32'h0000_0021, 6'h10, 9'd41, 9'd10, 32'h1111_0000, 1);
        do_lookup(32'h0000_0021, 6'h10, "R6 cleared");
        chk(rsp_tgt_ok == 1'b0, "R6 tok cleared", 64'(rsp_tgt_ok), 0);

        // R4: no-fault update ignored (up_ready stays high)
        do_update(0, 0, 1, 32'h0000_0021, 6'h10, 9'd99, 9'd1, 32'h2222_0000, 0);
        chk(up_ready == 1'b1, "R4 ready stays", 64'(up_ready), 1);
        do_lookup(32'h0000_0021, 6'h10, "R4 untouched");
        chk(rsp_dist == 9'd31, "R4 dist kept", 64'(rsp_dist), 31);

        // R5: kill clears valid
        do_update(1, 1, 0, 32'h0000_4008, 6'h0C, 9'd0, 9'd0, 32'h0, 1);
        do_lookup(32'h0000_4008, 6'h0C, "R5 killed");
        chk(rsp_hit == 1'b0, "R5 miss", 64'(rsp_hit), 0);
        chk(rsp_dist == '0, "R9 zero dist", 64'(rsp_dist), 0);

        // R8: update offered while busy is ignored
        up_valid = 1'b1; up_wpe_seen = 1'b1; up_kill = 1'b0; up_is_indirect = 1'b0;
        up_wpe_pc = 32'h0000_0030; up_wpe_hist = 6'h00; up_wpe_seq = 9'd7; up_br_seq = 9'd2;
        @(posedge clk); @(negedge clk);
        model_write(1, 0, 0, 32'h0000_0030, 6'h00, 9'd7, 9'd2, 32'h0);
        up_wpe_pc = 32'h0000_0011; up_wpe_hist = 6'h00; // offered while busy
        @(negedge clk);
        up_valid = 1'b0;
        @(negedge clk);
        chk(up_ready == 1'b1, "R8 back ready", 64'(up_ready), 1);
        do_lookup(32'h0000_0011, 6'h00, "R8 ignored");
        do_lookup(32'h0000_0030, 6'h00, "R8 first");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [PC_W-1:0] pc;
            logic [IDX_W-1:0] h;
            pc = $urandom; h = IDX_W'($urandom);
            if (($urandom % 2) == 0) begin
                do_update(($urandom % 4) != 0, ($urandom % 7) == 0, $urandom % 2, pc, h,
                          SEQ_W'($urandom), SEQ_W'($urandom), $urandom, 1);
            end else begin
                do_lookup(pc, h, "RND R3");
            end
        end

        done = 1'b1;
        summary();
    end
endmodule